// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the sequencer of a small 8-bit computer built around a shared bus. On every rising edge of the control clock it takes a snapshot of the instruction byte and the four ALU flag bits, and it moves a microstep counter on by one. The snapshot and the step number together address a microcode table. The table returns a 32-bit word of strobes that tells the registers, the ALU, the memory, the stack pointer and the program counter what to do during the current microstep. The strobes also include a step-end bit and a halt bit.

The strobes are produced only from registered state. An instruction byte or flag change that arrives between control-clock edges cannot move them, so they stay quiet around the data-clock edge that the datapath uses. Every opcode begins with the same two fetch steps. An opcode that needs fewer than eight steps raises its step-end strobe on its last step, and the counter returns to step 0 at the next edge instead of stepping through empty slots. A one-hot copy of the current step is provided for observation.

Top module: `ctl_seq`

## Requirements
- R1: The strobes during a clock period depend only on the instruction byte and flags sampled at the preceding rising edge and on the current step. A change of `instr_in` or `flags_in` between edges leaves `strobes` unchanged until the next rising edge.
- R2: With `rst` low and step-end clear, the step advances by one on each rising edge, and it wraps from 7 to 0. `step_oh` has exactly one bit set, bit i for step i.
- R3: A rising edge with `rst` high puts the step at 0. `step_oh` then reads 8'h01 and `strobes` shows the first fetch word.
- R4: When the step-end strobe (bit 28) is set, the step is 0 after the next rising edge.
- R5: At step 0 the strobes are pc_drive(bit 0) and mar_load(bit 3). At step 1 they are mem_drive(bit 4), ir_load(bit 7) and pc_inc(bit 2). Both words are the same for every instruction and flag value.
- R6: Strobe bit map: 0 pc_drive, 1 pc_load, 2 pc_inc, 3 mar_load, 4 mem_drive, 5 mem_write, 6 mem_data_sel (1 = data memory, 0 = program memory), 7 ir_load, 8 acc_load, 9 acc_drive, 10 ra_load, 11 ra_drive, 12 rb_load, 13 rb_drive, 14 rc_load, 15 rc_drive, 16 alu_keep_res, 17 alu_keep_flags, 18 alu_drive, 19 alu_a_from_bus (1 = bus, 0 = accumulator), 23:20 alu_fn, 24 alu_logic, 25 alu_carry, 26 sp_load, 27 sp_drive, 28 step_end, 29 halt. Bits 31:30 are always 0. Any step of a listed opcode that is not given below is all-zero.
- R7: Opcode 8'h01 (load immediate): step 2 is pc_drive+mar_load, and step 3 is mem_drive+acc_load+pc_inc+step_end. Opcode 8'h02: step 2 is acc_drive+ra_load+step_end. Opcode 8'h08: step 2 is ra_drive+rb_load+step_end.
- R8: Opcode 8'h03 (add A): step 2 is ra_drive+alu_fn 4'b1001+alu_keep_res+alu_keep_flags. Opcode 8'h0A (subtract B): step 2 is rb_drive+alu_fn 4'b0110+alu_carry+alu_keep_res+alu_keep_flags. Opcode 8'h0B (AND C): step 2 is rc_drive+alu_fn 4'b1011+alu_logic+alu_keep_res. For all three, step 3 is alu_drive+acc_load+step_end.
- R9: Opcode 8'h04 (jump): step 2 is pc_drive+mar_load, and step 3 is mem_drive+pc_load+step_end. Opcode 8'h05 (jump if zero) behaves like 8'h04 when flag bit 1 is 1. When that bit is 0, its step 2 is pc_inc+step_end.
- R10: Opcode 8'h06 (store): step 2 is pc_drive+mar_load, step 3 is mem_drive+mar_load+pc_inc, and step 4 is acc_drive+mem_write+mem_data_sel+step_end. Opcode 8'h07 (push): step 2 is sp_drive+mar_load, step 3 is acc_drive+mem_write+mem_data_sel, step 4 is sp_drive+alu_a_from_bus+alu_keep_res (alu_fn 0), step 5 is alu_drive+sp_load, and steps 6 and 7 are empty.
- R11: Opcode 8'hFF: step 2 is halt+step_end. Opcode 8'h00 and every opcode not listed: step 2 is step_end alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the step counter |
| instr_in | input | 8 | Instruction byte from the instruction register |
| flags_in | input | 4 | ALU flag bits |
| strobes | output | 32 | Control strobe word for the current microstep |
| step_oh | output | 8 | One-hot view of the current microstep |

## Verification
Each opcode is held steady long enough to run through its whole sequence. This separates correct per-step words from errors in the step order or in the early step-end. The conditional jump is run with the zero flag set and with it clear, and a flag bit that is not decoded is also toggled, which shows that only the chosen flag steers the branch. Random bytes and flags are applied every cycle to show that the fetch words do not depend on them and that decode follows the value sampled at the edge. A full sweep of all 256 opcodes covers the step-end path for undefined codes, and a reset in the middle of a push and the natural 7-to-0 wrap test the counter paths on their own.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] ctl_word_t;

  // strobe bit positions
  localparam int S_PC_DRIVE   = 0;
  localparam int S_PC_LOAD    = 1;
  localparam int S_PC_INC     = 2;
  localparam int S_MAR_LOAD   = 3;
  localparam int S_MEM_DRIVE  = 4;
  localparam int S_MEM_WRITE  = 5;
  localparam int S_MEM_DATA   = 6;
  localparam int S_IR_LOAD    = 7;
  localparam int S_ACC_LOAD   = 8;
  localparam int S_ACC_DRIVE  = 9;
  localparam int S_RA_LOAD    = 10;
  localparam int S_RA_DRIVE   = 11;
  localparam int S_RB_LOAD    = 12;
  localparam int S_RB_DRIVE   = 13;
  localparam int S_RC_LOAD    = 14;
  localparam int S_RC_DRIVE   = 15;
  localparam int S_ALU_RES    = 16;
  localparam int S_ALU_FLG    = 17;
  localparam int S_ALU_DRIVE  = 18;
  localparam int S_ALU_A_BUS  = 19;
  localparam int S_ALU_FN_LO  = 20;
  localparam int S_ALU_LOGIC  = 24;
  localparam int S_ALU_CARRY  = 25;
  localparam int S_SP_LOAD    = 26;
  localparam int S_SP_DRIVE   = 27;
  localparam int S_STEP_END   = 28;
  localparam int S_HALT       = 29;

  localparam ctl_word_t FETCH0 = (ctl_word_t'(1) << S_PC_DRIVE) | (ctl_word_t'(1) << S_MAR_LOAD);
  localparam ctl_word_t FETCH1 = (ctl_word_t'(1) << S_MEM_DRIVE) | (ctl_word_t'(1) << S_IR_LOAD) |
                                 (ctl_word_t'(1) << S_PC_INC);

  localparam logic [7:0] OP_NOP  = 8'h00;
  localparam logic [7:0] OP_LDI  = 8'h01;
  localparam logic [7:0] OP_MVA  = 8'h02;
  localparam logic [7:0] OP_ADD  = 8'h03;
  localparam logic [7:0] OP_JMP  = 8'h04;
  localparam logic [7:0] OP_JZ   = 8'h05;
  localparam logic [7:0] OP_STO  = 8'h06;
  localparam logic [7:0] OP_PUSH = 8'h07;
  localparam logic [7:0] OP_MVB  = 8'h08;
  localparam logic [7:0] OP_SUB  = 8'h0A;
  localparam logic [7:0] OP_AND  = 8'h0B;
  localparam logic [7:0] OP_HALT = 8'hFF;
endpackage

// File: rtl/ctl_shadow.sv
module ctl_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // copy taken on every control edge; forms part of the lookup address
  always_ff @(posedge clk) begin
    q <= d;
  end
endmodule

// File: rtl/ctl_step_ctr.sv
module ctl_step_ctr #(
  parameter int STEPS = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  output logic [$clog2(STEPS)-1:0] step_q,
  output logic [STEPS-1:0]         step_oh
);
  localparam int SW = $clog2(STEPS);

  logic [SW-1:0]    step_d;
  logic [STEPS-1:0] oh_d;

  always_comb begin
    if (rst || clear)
      step_d = '0;
    else if (step_q == SW'(STEPS - 1))
      step_d = '0;
    else
      step_d = step_q + SW'(1);
  end

  genvar gi;
  generate
    for (gi = 0; gi < STEPS; gi++) begin : g_dec
      assign oh_d[gi] = (step_d == SW'(gi));
    end
  endgenerate

  always_ff @(posedge clk) begin
    step_q  <= step_d;
    step_oh <= oh_d;
  end

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (step_q == '0)); // R3
  AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!clear && step_q != SW'(STEPS - 1)) |=> (step_q == SW'($past(step_q) + SW'(1)))); // R2
  AST_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!clear && step_q == SW'(STEPS - 1)) |=> (step_q == '0)); // R2
  AST_EARLY_END: assert property (@(posedge clk) disable iff (rst)
    clear |=> (step_q == '0)); // R4
  AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    $countones(step_oh) == 1); // R2
endmodule

// File: rtl/ctl_ucode.sv
module ctl_ucode
  import ctl_seq_pkg::*;
#(
  parameter int INSTR_W = 8,
  parameter int FLAG_W  = 4,
  parameter int STEP_W  = 3,
  parameter int ZF_BIT  = 1
) (
  input  logic [INSTR_W-1:0] op,
  input  logic [FLAG_W-1:0]  fl,
  input  logic [STEP_W-1:0]  st,
  output ctl_word_t          word
);
  localparam logic [FLAG_W-1:0] ZF_MASK = FLAG_W'(1) << ZF_BIT;

  function automatic ctl_word_t bitw(input int pos);
    return ctl_word_t'(1) << pos;
  endfunction

  function automatic ctl_word_t fnw(input logic [3:0] f);
    return ctl_word_t'(f) << S_ALU_FN_LO;
  endfunction

  function automatic ctl_word_t decode(input logic [INSTR_W-1:0] o,
                                       input logic [FLAG_W-1:0] f,
                                       input logic [STEP_W-1:0] s);
    ctl_word_t w;
    logic      zf;
    w  = '0;
    zf = |(f & ZF_MASK);
    if (s == STEP_W'(0)) begin
      w = FETCH0;
    end else if (s == STEP_W'(1)) begin
      w = FETCH1;
    end else begin
      case (o)
        INSTR_W'(OP_LDI): case (s)
          STEP_W'(2): w = bitw(S_PC_DRIVE) | bitw(S_MAR_LOAD);
          STEP_W'(3): w = bitw(S_MEM_DRIVE) | bitw(S_ACC_LOAD) | bitw(S_PC_INC) | bitw(S_STEP_END);
          default:    w = '0;
        endcase
        INSTR_W'(OP_MVA):
          w = (s == STEP_W'(2)) ? (bitw(S_ACC_DRIVE) | bitw(S_RA_LOAD) | bitw(S_STEP_END)) : '0;
        INSTR_W'(OP_MVB):
          w = (s == STEP_W'(2)) ? (bitw(S_RA_DRIVE) | bitw(S_RB_LOAD) | bitw(S_STEP_END)) : '0;
        INSTR_W'(OP_ADD), INSTR_W'(OP_SUB), INSTR_W'(OP_AND): case (s)
          STEP_W'(2): begin
            if (o == INSTR_W'(OP_ADD))
              w = bitw(S_RA_DRIVE) | fnw(4'b1001) | bitw(S_ALU_RES) | bitw(S_ALU_FLG);
            else if (o == INSTR_W'(OP_SUB))
              w = bitw(S_RB_DRIVE) | fnw(4'b0110) | bitw(S_ALU_CARRY) | bitw(S_ALU_RES) | bitw(S_ALU_FLG);
            else
              w = bitw(S_RC_DRIVE) | fnw(4'b1011) | bitw(S_ALU_LOGIC) | bitw(S_ALU_RES);
          end
          STEP_W'(3): w = bitw(S_ALU_DRIVE) | bitw(S_ACC_LOAD) | bitw(S_STEP_END);
          default:    w = '0;
        endcase
        INSTR_W'(OP_JMP), INSTR_W'(OP_JZ): begin
          if (o == INSTR_W'(OP_JZ) && !zf) begin
            w = (s == STEP_W'(2)) ? (bitw(S_PC_INC) | bitw(S_STEP_END)) : '0;
          end else begin
            case (s)
              STEP_W'(2): w = bitw(S_PC_DRIVE) | bitw(S_MAR_LOAD);
              STEP_W'(3): w = bitw(S_MEM_DRIVE) | bitw(S_PC_LOAD) | bitw(S_STEP_END);
              default:    w = '0;
            endcase
          end
        end
        INSTR_W'(OP_STO): case (s)
          STEP_W'(2): w = bitw(S_PC_DRIVE) | bitw(S_MAR_LOAD);
          STEP_W'(3): w = bitw(S_MEM_DRIVE) | bitw(S_MAR_LOAD) | bitw(S_PC_INC);
          STEP_W'(4): w = bitw(S_ACC_DRIVE) | bitw(S_MEM_WRITE) | bitw(S_MEM_DATA) | bitw(S_STEP_END);
          default:    w = '0;
        endcase
        INSTR_W'(OP_PUSH): case (s)
          STEP_W'(2): w = bitw(S_SP_DRIVE) | bitw(S_MAR_LOAD);
          STEP_W'(3): w = bitw(S_ACC_DRIVE) | bitw(S_MEM_WRITE) | bitw(S_MEM_DATA);
          STEP_W'(4): w = bitw(S_SP_DRIVE) | bitw(S_ALU_A_BUS) | bitw(S_ALU_RES);
          STEP_W'(5): w = bitw(S_ALU_DRIVE) | bitw(S_SP_LOAD);
          default:    w = '0;
        endcase
        INSTR_W'(OP_HALT):
          w = (s == STEP_W'(2)) ? (bitw(S_HALT) | bitw(S_STEP_END)) : '0;
        default:
          w = (s == STEP_W'(2)) ? bitw(S_STEP_END) : '0;
      endcase
    end
    return w;
  endfunction

  always_comb begin
    word = decode(op, fl, st);
  end
endmodule

// File: rtl/ctl_seq.sv
module ctl_seq
  import ctl_seq_pkg::*;
#(
  parameter int INSTR_W = 8,
  parameter int FLAG_W  = 4,
  parameter int STEPS   = 8,
  parameter int ZF_BIT  = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr_in,
  input  logic [FLAG_W-1:0]  flags_in,
  output logic [WORD_W-1:0]  strobes,
  output logic [STEPS-1:0]   step_oh
);
  localparam int STEP_W = $clog2(STEPS);

  logic [INSTR_W-1:0] instr_q;
  logic [FLAG_W-1:0]  flags_q;
  logic [STEP_W-1:0]  step_q;
  ctl_word_t          word;

  ctl_shadow #(.W(INSTR_W)) u_instr_shadow (.clk(clk), .d(instr_in), .q(instr_q));
  ctl_shadow #(.W(FLAG_W))  u_flag_shadow  (.clk(clk), .d(flags_in), .q(flags_q));

  ctl_step_ctr #(.STEPS(STEPS)) u_step (
    .clk    (clk),
    .rst    (rst),
    .clear  (word[S_STEP_END]),
    .step_q (step_q),
    .step_oh(step_oh)
  );

  ctl_ucode #(
    .INSTR_W(INSTR_W),
    .FLAG_W (FLAG_W),
    .STEP_W (STEP_W),
    .ZF_BIT (ZF_BIT)
  ) u_ucode (
    .op  (instr_q),
    .fl  (flags_q),
    .st  (step_q),
    .word(word)
  );

  assign strobes = word;

  AST_FETCH_FIRST: assert property (@(posedge clk) disable iff (rst)
    step_oh[0] |-> (strobes == FETCH0)); // R5
  AST_FETCH_SECOND: assert property (@(posedge clk) disable iff (rst)
    step_oh[1] |-> (strobes == FETCH1)); // R5
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
    strobes[WORD_W-1:WORD_W-2] == 2'b00); // R6
endmodule

// File: tb/ctl_seq_bench.sv
module ctl_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] instr_in = 8'h00;
  logic [3:0] flags_in = 4'h0;
  wire [31:0] strobes;
  wire [7:0]  step_oh;

  ctl_seq u_ctl_seq (
    .clk(clk), .rst(rst), .instr_in(instr_in), .flags_in(flags_in),
    .strobes(strobes), .step_oh(step_oh)
  );

  always #2 clk = ~clk;

  localparam bit [31:0] PCD = 32'd1 << 0,  PCL = 32'd1 << 1,  PCI = 32'd1 << 2,  MAR = 32'd1 << 3;
  localparam bit [31:0] MMD = 32'd1 << 4,  MMW = 32'd1 << 5,  MDS = 32'd1 << 6,  IRL = 32'd1 << 7;
  localparam bit [31:0] ACL = 32'd1 << 8,  ACD = 32'd1 << 9,  RAL = 32'd1 << 10, RAD = 32'd1 << 11;
  localparam bit [31:0] RBL = 32'd1 << 12, RBD = 32'd1 << 13, RCL = 32'd1 << 14, RCD = 32'd1 << 15;
  localparam bit [31:0] KRS = 32'd1 << 16, KFL = 32'd1 << 17, ALD = 32'd1 << 18, ABS = 32'd1 << 19;
  localparam bit [31:0] LOG = 32'd1 << 24, CRY = 32'd1 << 25, SPL = 32'd1 << 26, SPD = 32'd1 << 27;
  localparam bit [31:0] END = 32'd1 << 28, HLT = 32'd1 << 29;

  function automatic bit [31:0] efn(bit [7:0] op, bit [3:0] fl, int st);
    if (st == 0) return PCD | MAR;
    if (st == 1) return MMD | IRL | PCI;
    case (op)
      8'h01: return (st == 2) ? (PCD | MAR) : (st == 3) ? (MMD | ACL | PCI | END) : 0;
      8'h02: return (st == 2) ? (ACD | RAL | END) : 0;
      8'h08: return (st == 2) ? (RAD | RBL | END) : 0;
      8'h03: return (st == 2) ? (RAD | (32'd9 << 20) | KRS | KFL) : (st == 3) ? (ALD | ACL | END) : 0;
      8'h0A: return (st == 2) ? (RBD | (32'd6 << 20) | CRY | KRS | KFL) : (st == 3) ? (ALD | ACL | END) : 0;
      8'h0B: return (st == 2) ? (RCD | (32'd11 << 20) | LOG | KRS) : (st == 3) ? (ALD | ACL | END) : 0;
      8'h04: return (st == 2) ? (PCD | MAR) : (st == 3) ? (MMD | PCL | END) : 0;
      8'h05: begin
        if (fl[1]) return (st == 2) ? (PCD | MAR) : (st == 3) ? (MMD | PCL | END) : 0;
        return (st == 2) ? (PCI | END) : 0;
      end
      8'h06: return (st == 2) ? (PCD | MAR) : (st == 3) ? (MMD | MAR | PCI) :
                    (st == 4) ? (ACD | MMW | MDS | END) : 0;
      8'h07: return (st == 2) ? (SPD | MAR) : (st == 3) ? (ACD | MMW | MDS) :
                    (st == 4) ? (SPD | ABS | KRS) : (st == 5) ? (ALD | SPL) : 0;
      8'hFF: return (st == 2) ? (HLT | END) : 0;
      default: return (st == 2) ? END : 0;
    endcase
  endfunction

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R3";
  bit    mvalid = 0;
  bit    done = 0;
  bit [7:0] mi = 0;
  bit [3:0] mf = 0;
  int    ms = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h step=%0d op=%h", tag, act, exp, ms, mi);
    end
  endtask

  // reference model: state after each rising edge
  always @(posedge clk) begin
    bit [31:0] cur;
    cur = efn(mi, mf, ms);
    if (rst || cur[28]) ms = 0;
    else ms = (ms + 1) % 8;
    mi = instr_in;
    mf = flags_in;
    mvalid = 1;
  end

  always @(negedge clk) begin
    if (mvalid && !done) begin
      chk(cur_req, strobes, efn(mi, mf, ms));
      chk("R2", {24'h0, step_oh}, 32'(1 << ms));
      chk("R6", {30'h0, strobes[31:30]}, 32'h0);
    end
  end

  task automatic run(bit [7:0] op, bit [3:0] fl, string tag, int cycles);
    @(negedge clk);
    cur_req = tag;
    instr_in = op;
    flags_in = fl;
    repeat (cycles - 1) @(negedge clk);
  endtask

  task automatic wait_step(int s);
    while (ms != s) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    chk("R3 reset one-hot", {24'h0, step_oh}, 32'h1);
    chk("R3 reset word", strobes, PCD | MAR);
    rst = 1'b0;

    run(8'h00, 4'h0, "R11 nop", 10);
    run(8'h01, 4'h0, "R7 R4 load", 12);
    run(8'h02, 4'h3, "R7 move", 10);
    run(8'h08, 4'h0, "R7 move b", 10);
    run(8'h03, 4'h0, "R8 add", 12);
    run(8'h0A, 4'h5, "R8 sub", 12);
    run(8'h0B, 4'h0, "R8 and", 12);
    run(8'h04, 4'h0, "R9 jump", 12);
    run(8'h05, 4'h2, "R9 jz taken", 12);
    run(8'h05, 4'h0, "R9 jz not taken", 12);
    run(8'h05, 4'hD, "R9 jz other flags", 12);
    run(8'h06, 4'h0, "R10 store", 15);
    run(8'h07, 4'h0, "R10 push", 20);

    // R2: natural wrap 7 -> 0 during a push
    wait_step(7);
    @(negedge clk);
    chk("R2 wrap", {24'h0, step_oh}, 32'h1);

    run(8'hFF, 4'h0, "R11 halt", 10);
    run(8'h5A, 4'h0, "R11 undefined", 10);

    // R1: input change between edges does not move strobes
    run(8'h01, 4'h0, "R1", 2);
    wait_step(2);
    held = strobes;
    instr_in = 8'h07;
    flags_in = 4'hF;
    #1;
    chk("R1 hold between edges", strobes, held);
    run(8'h07, 4'h0, "R1", 4);

    // R3: reset in the middle of a push
    run(8'h07, 4'h0, "R3 mid reset", 2);
    wait_step(4);
    rst = 1'b1;
    @(negedge clk);
    chk("R3 mid reset step", {24'h0, step_oh}, 32'h1);
    rst = 1'b0;
    repeat (10) @(negedge clk);

    // R5: random inputs every cycle
    cur_req = "R5 random";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      instr_in = (i % 3 == 0) ? 8'($urandom_range(0, 255)) : 8'($urandom_range(0, 12));
      flags_in = 4'($urandom_range(0, 15));
    end

    // full opcode sweep
    for (int op = 0; op < 256; op++) begin
      run(8'(op), 4'h0, "R11 sweep", 5);
      run(8'(op), 4'hF, "R11 sweep", 5);
    end

    @(negedge clk);
    finish_run();
  end
endmodule